// File: doc/BRIEF.md
# VCO Band-Select Calibration Controller

This block chooses the capacitor-bank code that puts a synthesizer's VCO on the right tuning curve for a requested channel. It runs a binary search over the band codes. For each trial code it first waits for the VCO to settle. It then counts divided-VCO edges over a fixed window of reference cycles and compares that count with a target count worked out from the channel word.

The comparison allows a tolerance band. A count inside the band ends the search at once. Otherwise the search steps down when the count is high and up when it is low, halving the step after each trial. The block remembers which trial gave the smallest absolute error. When the steps run out it returns that code, so it never needs a repeat or a final extra comparison. The divided-VCO input arrives as a one-cycle strobe, already moved into the reference clock domain. The same search serves targets in both frequency bands, since only the target count changes between them.

Top module: `vco_band_cal`

## Requirements
- R1: During and after reset, busy_o and done_o are 0 and band_code_o is 16, the middle of the 5-bit code range.
- R2: A start_i sampled high while idle sets busy_o in the next cycle, and band_code_o becomes 16 for the first trial.
- R3: Each trial lasts max(settle_i,1) settling cycles, then WIN (256) counting cycles, then one judging cycle. A search of N trials therefore holds busy_o high for exactly N*(max(settle_i,1)+257) cycles.
- R4: Each reference cycle of the counting window in which vco_edge_i is high adds one to the trial count. Strobes seen during settling or while idle are not counted.
- R5: If count > target_i + 2, the next trial code is the current code minus the step. If count < target_i − 2, the next code is the current code plus the step. The step is 8 after the first trial, then 4, 2 and 1, so a search has at most 5 trials.
- R6: If |count − target_i| ≤ 2, the search ends after that trial and band_code_o keeps that code.
- R7: After a fifth trial that lands outside the tolerance, band_code_o becomes the trial code with the smallest absolute error. A later trial replaces the stored code only if its error is strictly smaller.
- R8: done_o is high for exactly one cycle, the first cycle with busy_o low after a search. band_code_o then holds its value until the next accepted start.
- R9: start_i while busy_o is high is ignored: trial codes, timing and the result are unchanged.
- R10: A start_i high in the done_o cycle is accepted: busy_o is high in the next cycle with band_code_o at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration (only honoured while idle) |
| target_i | input | 9 | Target edge count for the requested channel |
| settle_i | input | 8 | Settling cycles after each code change (0 acts as 1) |
| vco_edge_i | input | 1 | One-cycle strobe per divided-VCO rising edge |
| band_code_o | output | 5 | Capacitor-bank code: the trial code, then the result |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
Two events can fall in the same cycle: the done_o pulse that ends one search and a start_i that begins the next. The bench raises start_i during the cycle in which it sees done_o high. It then requires busy_o to be high and band_code_o to be back at 16 in the following cycle, after the previous result was shown for exactly that one cycle. A behavioural model runs alongside and is compared on every clock. It also checks the opposite case: start pulses that fall inside a search must leave the trial sequence and the busy time unchanged.

// File: rtl/vco_cal_pkg.sv
package vco_cal_pkg;
  typedef enum logic [1:0] {WIN_IDLE, WIN_SETTLE, WIN_COUNT} win_phase_e;
  typedef enum logic {CAL_IDLE, CAL_RUN} cal_state_e;
endpackage

// File: rtl/vco_cal_window.sv
module vco_cal_window
  import vco_cal_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int WIN   = 256,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             edge_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int WIN_W = $clog2(WIN);
  localparam int TMR_W = (SET_W > WIN_W) ? SET_W : WIN_W;

  win_phase_e       phase;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W:0]   tmr_inc;
  logic [TMR_W:0]   settle_eff;

  assign tmr_inc    = {1'b0, tmr} + (TMR_W+1)'(1);
  assign settle_eff = (settle_i == '0) ? (TMR_W+1)'(1) : (TMR_W+1)'(settle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase        <= WIN_IDLE;
      tmr          <= '0;
      count_o      <= '0;
      meas_valid_o <= 1'b0;
    end else begin
      meas_valid_o <= 1'b0;
      unique case (phase)
        WIN_IDLE: if (arm_i) begin
          phase <= WIN_SETTLE;
          tmr   <= '0;
        end
        WIN_SETTLE: begin
          if (tmr_inc >= settle_eff) begin
            phase   <= WIN_COUNT;
            tmr     <= '0;
            count_o <= '0;
          end else begin
            tmr <= tmr_inc[TMR_W-1:0];
          end
        end
        WIN_COUNT: begin
          count_o <= count_o + CNT_W'(edge_i);
          if (tmr == TMR_W'(WIN - 1)) begin
            phase        <= WIN_IDLE;
            meas_valid_o <= 1'b1;
          end else begin
            tmr <= tmr_inc[TMR_W-1:0];
          end
        end
        default: phase <= WIN_IDLE;
      endcase
    end
  end

  // R4: count never exceeds the window length
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(WIN));

  // R4: a result only follows a counting phase
  a_r4_valid_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_valid_o |-> $past(phase == WIN_COUNT));

  // R3: settling is never skipped after arming
  a_r3_settle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == WIN_IDLE && arm_i) |=> phase == WIN_SETTLE);
endmodule

// File: rtl/vco_cal_cmp.sv
module vco_cal_cmp #(
  parameter int CNT_W = 9,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] abs_err_o,
  output logic             above_o,
  output logic             below_o
);
  localparam int EXT = CNT_W + 2;

  logic signed [EXT-1:0] diff;
  logic signed [EXT-1:0] tol_s;
  logic signed [EXT-1:0] mag;

  assign tol_s     = EXT'(TOL);
  assign diff      = $signed({2'b00, count_i}) - $signed({2'b00, target_i});
  assign mag       = (diff < 0) ? -diff : diff;
  assign abs_err_o = mag[CNT_W-1:0];
  assign above_o   = diff > tol_s;
  assign below_o   = diff < -tol_s;

  // R5: never both directions at once
  always_comb begin
    a_r5_one_direction: assert (!(above_o && below_o));
  end
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
  import vco_cal_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int SET_W  = 8,
  parameter int WIN    = 256,
  parameter int TOL    = 2,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic              vco_edge_i,
  output logic [CODE_W-1:0] band_code_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] MID   = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CODE_W-1:0] STEP0 = CODE_W'(1 << (CODE_W - 2));

  cal_state_e        state;
  logic [CODE_W-1:0] step;
  logic [CODE_W-1:0] best_code;
  logic [CNT_W:0]    best_err;
  logic              meas_valid;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  abs_err;
  logic              above, below;
  logic              accept, judging, better, finish, arm;

  vco_cal_window #(.SET_W(SET_W), .WIN(WIN)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .settle_i    (settle_i),
    .edge_i      (vco_edge_i),
    .meas_valid_o(meas_valid),
    .count_o     (count)
  );

  vco_cal_cmp #(.CNT_W(CNT_W), .TOL(TOL)) u_cmp (
    .count_i  (count),
    .target_i (target_i),
    .abs_err_o(abs_err),
    .above_o  (above),
    .below_o  (below)
  );

  assign accept  = (state == CAL_IDLE) && start_i;
  assign judging = (state == CAL_RUN) && meas_valid;
  assign better  = {1'b0, abs_err} < best_err;
  assign finish  = judging && ((!above && !below) || (step == '0));
  assign arm     = accept || (judging && !finish);
  assign busy_o  = (state == CAL_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= CAL_IDLE;
      band_code_o <= MID;
      step        <= STEP0;
      best_code   <= MID;
      best_err    <= '1;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        state       <= CAL_RUN;
        band_code_o <= MID;
        step        <= STEP0;
        best_code   <= MID;
        best_err    <= '1;
      end else if (judging) begin
        if (better) begin
          best_err  <= {1'b0, abs_err};
          best_code <= band_code_o;
        end
        if (finish) begin
          state       <= CAL_IDLE;
          band_code_o <= better ? band_code_o : best_code;
          done_o      <= 1'b1;
        end else begin
          band_code_o <= above ? band_code_o - step : band_code_o + step;
          step        <= step >> 1;
        end
      end
    end
  end

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(band_code_o));

  a_r2_start_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && band_code_o == MID));

  // R9: between judgements the code cannot move, start or not
  a_r9_code_stable_midtrial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !meas_valid) |=> $stable(band_code_o));

  a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (judging && above && !finish) |=> band_code_o < $past(band_code_o));

  a_r5_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (judging && below && !finish) |=> band_code_o > $past(band_code_o));

  a_r6_inside_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (judging && !above && !below) |=> (band_code_o == $past(band_code_o) && done_o));
endmodule

// File: tb/vco_band_cal_tb.sv
`timescale 1ns/1ps
module vco_band_cal_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] target_i = '0;
  logic [7:0] settle_i = 8'd64;
  logic       vco_edge = 1'b0;
  logic [4:0] band_code_o;
  logic       busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;

  always #2.5 clk = ~clk;

  vco_band_cal u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .target_i(target_i),
    .settle_i(settle_i), .vco_edge_i(vco_edge), .band_code_o(band_code_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int rate(input int c);
    return 20 + 7 * c;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // transaction-level expectation: final code and trial count
  function automatic void ref_search(input int tgt, output int fcode, output int ntr);
    int c = 16, st = 8, be = 1 << 30, bc = 16, e;
    ntr = 0;
    while (1) begin
      ntr++;
      e = iabs(rate(c) - tgt);
      if (e < be) begin be = e; bc = c; end
      if (e <= 2 || st == 0) begin fcode = bc; break; end
      c = (rate(c) > tgt) ? c - st : c + st;
      st = st / 2;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model: 0 idle, 1 settle, 2 count, 3 judge
  int fr = 0;
  int m_st = 0, m_code = 16, m_step = 8, m_tmr = 0, m_cnt = 0;
  int m_be = 0, m_bc = 16, m_done = 0, m_busy = 0;

  always @(posedge clk) begin
    int e, se;
    fr++;
    if (rst_n) begin
      m_done = 0;
      se = (settle_i == 0) ? 1 : int'(settle_i);
      case (m_st)
        0: if (start_i) begin
          m_st = 1; m_code = 16; m_step = 8; m_tmr = 0; m_be = 1 << 30; m_bc = 16;
        end
        1: begin
          m_tmr++;
          if (m_tmr >= se) begin m_st = 2; m_tmr = 0; m_cnt = 0; end
        end
        2: begin
          m_cnt += int'(vco_edge);
          m_tmr++;
          if (m_tmr == 256) m_st = 3;
        end
        default: begin
          e = iabs(m_cnt - int'(target_i));
          if (e < m_be) begin m_be = e; m_bc = m_code; end
          if (e <= 2 || m_step == 0) begin
            m_st = 0; m_code = m_bc; m_done = 1;
          end else begin
            m_code = (m_cnt > int'(target_i)) ? m_code - m_step : m_code + m_step;
            m_step = m_step / 2; m_st = 1; m_tmr = 0;
          end
        end
      endcase
      m_busy = (m_st != 0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(busy_o) == m_busy, "R2 busy vs model", int'(busy_o), m_busy);
      chk(int'(band_code_o) == m_code, "R5 code vs model", int'(band_code_o), m_code);
      chk(int'(done_o) == m_done, "R8 done vs model", int'(done_o), m_done);
      if (busy_o) busy_cnt++;
    end
    vco_edge = ((fr % 256) < rate(int'(band_code_o)));
  end

  task automatic run(input int tgt, input int st, input bit poke, input string tag);
    int fc, nt, se;
    ref_search(tgt, fc, nt);
    se = (st == 0) ? 1 : st;
    @(negedge clk);
    target_i = 9'(tgt); settle_i = 8'(st); start_i = 1'b1; busy_cnt = 0;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      start_i = 1'b1;
      repeat (2) @(negedge clk);
      start_i = 1'b0;
      repeat (400) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk(int'(band_code_o) == fc, tag, int'(band_code_o), fc);
    chk(busy_cnt == nt * (se + 257), "R3 busy length", busy_cnt, nt * (se + 257));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fc, nt;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", int'({busy_o, done_o}), 0);
    chk(band_code_o == 5'd16, "R1 code in reset", int'(band_code_o), 16);
    rst_n = 1'b1;
    @(negedge clk);
    chk(band_code_o == 5'd16 && !busy_o, "R1 after reset", int'(band_code_o), 16);

    // R6: exact hit on the first code
    run(rate(16), 64, 1'b0, "R6 exact first trial");
    // R6: hit inside tolerance deeper in the search
    run(rate(23) + 2, 64, 1'b0, "R6 inside tolerance");
    // R7: best of five trials, between curves
    run(150, 64, 1'b0, "R7 best error between codes");
    run(rate(9) - 3, 64, 1'b0, "R7 best error low side");
    // R4/R5: target below every curve walks all the way down
    run(0, 64, 1'b0, "R5 floor target");
    // R4/R5: target above every curve walks all the way up
    run(400, 64, 1'b0, "R5 ceiling target");
    // R3: zero settle acts as one cycle, short settle too
    run(rate(16), 0, 1'b0, "R3 zero settle result");
    run(rate(5) + 1, 3, 1'b0, "R3 short settle result");
    // R9: start pulses during the search are ignored
    run(rate(27) - 4, 20, 1'b1, "R9 start while busy");

    // R10: new start in the done cycle
    run(rate(12), 10, 1'b0, "R10 first result");
    start_i = 1'b1;
    target_i = 9'(rate(30));
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after back-to-back start", int'(busy_o), 1);
    chk(band_code_o == 5'd16, "R10 restart at mid code", int'(band_code_o), 16);
    ref_search(rate(30), fc, nt);
    while (!done_o) @(negedge clk);
    chk(int'(band_code_o) == fc, "R10 second result", int'(band_code_o), fc);

    // R8: result held while idle
    repeat (20) @(negedge clk);
    chk(int'(band_code_o) == fc && !done_o, "R8 hold while idle", int'(band_code_o), fc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule